// File: doc/BRIEF.md
# Compressed Mode Switching Controller

This block tracks which decoding mode a variable-length instruction front end is in while a stream of 16-bit halfwords flows past it. The caller presents one halfword per cycle with a valid strobe, plus a flag that is high when the current major opcode picks out the compressed opcode space. The controller moves between four modes: standard 32-bit decoding, an entry compressed mode with 10 usable bits, full 16-bit compressed mode, and a transient mode that decodes one standard instruction before it falls back into 16-bit mode by itself.

Two marker bits of each compressed halfword control the moves: the high marker (bit 15) and the low marker (bit 0). Both bit positions are parameters. In 16-bit mode a halfword with both markers set is flagged as an immediate-form compressed instruction. The decoder downstream reads the registered mode and the immediate flag and selects its field layout from them. This block decodes no instruction fields.

Top module: `cmode_fsm`

## Requirements
- R1: A synchronous active-high reset puts the mode in standard (2'b00), drops the immediate flag and cancels any pending return to 16-bit mode. All of these are visible at the first sampling point after the reset edge.
- R2: A cycle with the valid strobe low leaves the mode unchanged, and the immediate flag is low after it. Such a cycle also does not advance a pending one-shot return.
- R3: In standard mode, an accepted halfword with the compressed-space flag high moves the mode to 10-bit (2'b01). With the flag low, the mode stays standard.
- R4: In 10-bit mode, an accepted halfword with bit 15 set moves the mode to 16-bit (2'b10).
- R5: In 10-bit mode, an accepted halfword with bit 15 clear moves the mode back to standard (2'b00).
- R6: In 16-bit mode, an accepted halfword with bit 15 and bit 0 both set raises the immediate flag for the following cycle, and the mode stays 16-bit.
- R7: In 16-bit mode, an accepted halfword with bit 15 set and bit 0 clear keeps the mode at 16-bit and leaves the immediate flag low.
- R8: In 16-bit mode, an accepted halfword with bit 15 and bit 0 both clear moves the mode to standard (2'b00).
- R9: In 16-bit mode, an accepted halfword with bit 15 clear and bit 0 set moves the mode to standard-then-16-bit (2'b11).
- R10: In standard-then-16-bit mode, the controller stays for exactly two accepted halfwords (one 32-bit instruction), ignoring the compressed-space flag. After the second one it moves to 16-bit mode (2'b10).
- R11: Only a halfword that qualifies under R6 raises the immediate flag, and the flag is registered: it is high in the cycle after that halfword and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hw_valid | input | 1 | Halfword on hw_data is accepted this cycle |
| hw_data | input | HW_W (16) | Instruction halfword; carries the two marker bits |
| cmp_sel | input | 1 | Current major opcode selects the compressed space |
| mode | output | 2 | Registered mode: 00 standard, 01 10-bit, 10 16-bit, 11 standard-then-16-bit |
| imm_flag | output | 1 | Registered: previous accepted halfword was an immediate-form compressed instruction |

## Verification
The bench aims at the one-shot return. It interrupts that mode with invalid cycles and with a raised compressed-space flag. A design that counted idle cycles would come back to 16-bit mode one halfword early. A design that obeyed the flag would drop into 10-bit mode. The bench covers all four marker combinations in 16-bit mode, because a swap of the two marker tests would send a plain compressed halfword to the one-shot mode or mark it immediate. A reset in the middle of a pending return checks that the pending count is cleared, so a later return still takes a full two halfwords.

// File: rtl/cmode_pkg.sv
package cmode_pkg;

    typedef enum logic [1:0] {
        MODE_STD     = 2'b00,
        MODE_C10     = 2'b01,
        MODE_C16     = 2'b10,
        MODE_STD_RET = 2'b11
    } cmode_e;

    typedef struct packed {
        cmode_e mode;
        logic   imm;
    } cmode_state_t;

    localparam cmode_state_t CMODE_RESET = '{mode: MODE_STD, imm: 1'b0};

endpackage

// File: rtl/cmode_ret_cnt.sv
// Counts accepted halfwords while a one-shot standard instruction is pending.
module cmode_ret_cnt #(
    parameter int STD_HW = 2,
    parameter int CW     = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic hw_valid,
    output logic last_hw
);

    logic [CW-1:0] cnt_d, cnt_q;

    assign last_hw = (cnt_q == CW'(STD_HW - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (!active) begin
            cnt_d = '0;
        end else if (hw_valid) begin
            cnt_d = last_hw ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

endmodule

// File: rtl/cmode_next.sv
// Pure next-state logic of the mode controller.
module cmode_next
    import cmode_pkg::*;
(
    input  cmode_state_t cur,
    input  logic         hw_valid,
    input  logic         cmp_sel,
    input  logic         mark_hi,
    input  logic         mark_lo,
    input  logic         ret_last,
    output cmode_state_t nxt
);

    always_comb begin
        nxt      = cur;
        nxt.imm  = 1'b0;
        if (hw_valid) begin
            unique case (cur.mode)
                MODE_STD: begin
                    if (cmp_sel) nxt.mode = MODE_C10;
                end
                MODE_C10: begin
                    nxt.mode = mark_hi ? MODE_C16 : MODE_STD;
                end
                MODE_C16: begin
                    if (mark_hi) begin
                        nxt.imm = mark_lo;
                    end else begin
                        nxt.mode = mark_lo ? MODE_STD_RET : MODE_STD;
                    end
                end
                MODE_STD_RET: begin
                    if (ret_last) nxt.mode = MODE_C16;
                end
                default: nxt.mode = MODE_STD;
            endcase
        end
    end

endmodule

// File: rtl/cmode_fsm.sv
module cmode_fsm
    import cmode_pkg::*;
#(
    parameter int HW_W   = 16,
    parameter int HI_BIT = 15,
    parameter int LO_BIT = 0,
    parameter int STD_HW = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            hw_valid,
    input  logic [HW_W-1:0] hw_data,
    input  logic            cmp_sel,
    output logic [1:0]      mode,
    output logic            imm_flag
);

    localparam int CW = (STD_HW > 1) ? $clog2(STD_HW) : 1;

    cmode_state_t st_d, st_q;
    logic         ret_last;
    logic         mark_hi, mark_lo;

    assign mark_hi = hw_data[HI_BIT];
    assign mark_lo = hw_data[LO_BIT];

    cmode_ret_cnt #(
        .STD_HW (STD_HW),
        .CW     (CW)
    ) u_ret_cnt (
        .clk      (clk),
        .rst      (rst),
        .active   (st_q.mode == MODE_STD_RET),
        .hw_valid (hw_valid),
        .last_hw  (ret_last)
    );

    cmode_next u_next (
        .cur      (st_q),
        .hw_valid (hw_valid),
        .cmp_sel  (cmp_sel),
        .mark_hi  (mark_hi),
        .mark_lo  (mark_lo),
        .ret_last (ret_last),
        .nxt      (st_d)
    );

    always_ff @(posedge clk) begin
        if (rst) st_q <= CMODE_RESET;
        else     st_q <= st_d;
    end

    assign mode     = st_q.mode;
    assign imm_flag = st_q.imm;

endmodule

// File: rtl/cmode_fsm_chk.sv
module cmode_fsm_chk #(
    parameter int HW_W   = 16,
    parameter int HI_BIT = 15,
    parameter int LO_BIT = 0,
    parameter int STD_HW = 2
) (
    input logic            clk,
    input logic            rst,
    input logic            hw_valid,
    input logic [HW_W-1:0] hw_data,
    input logic            cmp_sel,
    input logic [1:0]      mode,
    input logic            imm_flag
);

    logic hi, lo;
    int   ret_seen;

    assign hi = hw_data[HI_BIT];
    assign lo = hw_data[LO_BIT];

    always_ff @(posedge clk) begin
        if (rst || mode != 2'b11) ret_seen <= 0;
        else if (hw_valid)        ret_seen <= ret_seen + 1;
    end

    // R1
    reset_std_chk: assert property (@(posedge clk) rst |=> (mode == 2'b00 && !imm_flag));
    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !hw_valid |=> ($stable(mode) && !imm_flag));
    // R3
    enter_c10_chk: assert property (@(posedge clk) disable iff (rst)
        (hw_valid && mode == 2'b00 && cmp_sel) |=> mode == 2'b01);
    // R3
    std_stay_chk: assert property (@(posedge clk) disable iff (rst)
        (hw_valid && mode == 2'b00 && !cmp_sel) |=> mode == 2'b00);
    // R4
    c10_up_chk: assert property (@(posedge clk) disable iff (rst)
        (hw_valid && mode == 2'b01 && hi) |=> mode == 2'b10);
    // R5
    c10_back_chk: assert property (@(posedge clk) disable iff (rst)
        (hw_valid && mode == 2'b01 && !hi) |=> mode == 2'b00);
    // R6
    imm_mark_chk: assert property (@(posedge clk) disable iff (rst)
        (hw_valid && mode == 2'b10 && hi && lo) |=> (imm_flag && mode == 2'b10));
    // R7
    plain_c16_chk: assert property (@(posedge clk) disable iff (rst)
        (hw_valid && mode == 2'b10 && hi && !lo) |=> (!imm_flag && mode == 2'b10));
    // R8
    c16_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (hw_valid && mode == 2'b10 && !hi && !lo) |=> mode == 2'b00);
    // R9
    c16_oneshot_chk: assert property (@(posedge clk) disable iff (rst)
        (hw_valid && mode == 2'b10 && !hi && lo) |=> mode == 2'b11);
    // R10
    ret_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (hw_valid && mode == 2'b11 && ret_seen < STD_HW - 1) |=> mode == 2'b11);
    // R10
    ret_done_chk: assert property (@(posedge clk) disable iff (rst)
        (hw_valid && mode == 2'b11 && ret_seen >= STD_HW - 1) |=> mode == 2'b10);
    // R11
    imm_source_chk: assert property (@(posedge clk) disable iff (rst)
        imm_flag |-> $past(hw_valid && mode == 2'b10 && hi && lo));

endmodule

bind cmode_fsm cmode_fsm_chk #(
    .HW_W   (HW_W),
    .HI_BIT (HI_BIT),
    .LO_BIT (LO_BIT),
    .STD_HW (STD_HW)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .hw_valid (hw_valid),
    .hw_data  (hw_data),
    .cmp_sel  (cmp_sel),
    .mode     (mode),
    .imm_flag (imm_flag)
);

// File: tb/cmode_fsm_test.sv
`timescale 1ns/1ps
module cmode_fsm_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        hw_valid;
    logic [15:0] hw_data;
    logic        cmp_sel;
    logic [1:0]  mode;
    logic        imm_flag;

    int checks = 0;
    int fails  = 0;

    logic [1:0] m_mode;
    int         m_cnt;
    logic       m_imm;

    always #2.5 clk = ~clk;

    cmode_fsm uut (
        .clk      (clk),
        .rst      (rst),
        .hw_valid (hw_valid),
        .hw_data  (hw_data),
        .cmp_sel  (cmp_sel),
        .mode     (mode),
        .imm_flag (imm_flag)
    );

    // Reference model: returns the requirement that governs this step.
    function automatic string model(input logic r, input logic v,
                                    input logic [15:0] h, input logic s);
        string tag;
        logic  hi = h[15];
        logic  lo = h[0];
        m_imm = 1'b0;
        if (r) begin
            m_mode = 2'b00; m_cnt = 0; tag = "R1";
        end else if (!v) begin
            tag = "R2";
        end else begin
            case (m_mode)
                2'b00: begin m_mode = s ? 2'b01 : 2'b00; tag = "R3"; end
                2'b01: begin
                    m_mode = hi ? 2'b10 : 2'b00;
                    tag = hi ? "R4" : "R5";
                end
                2'b10: begin
                    if (hi) begin
                        m_imm = lo; tag = lo ? "R6" : "R7";
                    end else if (lo) begin
                        m_mode = 2'b11; m_cnt = 0; tag = "R9";
                    end else begin
                        m_mode = 2'b00; tag = "R8";
                    end
                end
                default: begin
                    m_cnt = m_cnt + 1; tag = "R10";
                    if (m_cnt == 2) begin m_mode = 2'b10; m_cnt = 0; end
                end
            endcase
        end
        return tag;
    endfunction

    // Called at a falling edge; samples results at the next falling edge.
    task automatic step(input logic r, input logic v,
                        input logic [15:0] h, input logic s);
        string tag;
        rst = r; hw_valid = v; hw_data = h; cmp_sel = s;
        tag = model(r, v, h, s);
        @(negedge clk);
        checks++;
        if (mode !== m_mode) begin
            fails++;
            $display("FAIL %s mode: actual %b expected %b", tag, mode, m_mode);
        end
        checks++;
        if (imm_flag !== m_imm) begin
            fails++;
            $display("FAIL %s imm_flag: actual %b expected %b",
                     m_imm ? "R6" : "R11", imm_flag, m_imm);
        end
    endtask

    initial begin
        #(5.0 * 200000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int seed_sink;
        seed_sink = $urandom(32'h5eed_c0de);
        m_mode = 2'b00; m_cnt = 0; m_imm = 1'b0;
        rst = 1'b1; hw_valid = 1'b0; hw_data = '0; cmp_sel = 1'b0;
        @(negedge clk);
        // R1 reset state
        step(1, 0, 16'h0000, 0);
        step(1, 1, 16'hFFFF, 1);
        // R2 idle, R3 standard stay and entry
        step(0, 0, 16'hFFFF, 1);
        step(0, 1, 16'h8001, 0);
        step(0, 1, 16'h0000, 1);
        // R4 to 16-bit, R6 immediate, R7 plain, R2 idle in 16-bit
        step(0, 1, 16'h8000, 0);
        step(0, 1, 16'h8001, 0);
        step(0, 1, 16'h8000, 0);
        step(0, 0, 16'h8001, 0);
        // R9 one-shot, R10 with gap and flag high, then back
        step(0, 1, 16'h0001, 0);
        step(0, 0, 16'h0000, 1);
        step(0, 1, 16'h8001, 1);
        step(0, 0, 16'h0000, 0);
        step(0, 1, 16'h0000, 1);
        // R8 exit, R3 enter, R5 back
        step(0, 1, 16'h0000, 0);
        step(0, 1, 16'h0000, 1);
        step(0, 1, 16'h7FFF, 0);
        // R1 reset during pending return, then full count again
        step(0, 1, 16'h0000, 1);
        step(0, 1, 16'hFFFE, 0);
        step(0, 1, 16'h0001, 0);
        step(0, 1, 16'h1234, 0);
        step(1, 0, 16'h0000, 0);
        step(0, 1, 16'h0000, 1);
        step(0, 1, 16'h8000, 0);
        step(0, 1, 16'h0001, 0);
        step(0, 1, 16'h4321, 0);
        step(0, 1, 16'h8765, 0);
        step(0, 1, 16'h8001, 0);
        // constrained random
        for (int i = 0; i < 6000; i++) begin
            logic        r = ($urandom_range(0, 199) == 0);
            logic        v = ($urandom_range(0, 9) < 8);
            logic [15:0] h = 16'($urandom);
            logic        s = ($urandom_range(0, 9) < 3);
            step(r, v, h, s);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule